// File: doc/BRIEF.md
# Timer Input Capture Unit

The block keeps a 16-bit free-running counter and watches an external capture input for one chosen transition. The capture input is brought into the clock domain through two flops. When the chosen transition shows up at the synchronizer output, the counter's current value is frozen into a 16-bit capture register and a capture flag goes high. Software can only read the capture register. It has no write path.

Software reads over an 8-bit port one byte at a time. A read of the low byte also copies the high byte into a shared holding byte. A later read of the high byte returns that holding byte, so both bytes come from the same capture even when a new capture lands between the two reads. Software clears the flag with a one-cycle strobe.

Top module: `tcap_unit`

## Requirements
- R1: After reset, the counter, the capture register, the holding byte, the flag and the read data output are all zero.
- R2: With `edge_fall`=0, only a 0-to-1 transition of `cap_in` causes a capture. With `edge_fall`=1, only a 1-to-0 transition does. A transition of the other direction leaves both the flag and the capture register unchanged.
- R3: `cap_in` passes through two flops. A change driven between clock edges causes the capture on the third following rising clock edge, and no earlier.
- R4: The capture register takes the counter value and the flag rises on the same clock edge.
- R5: A read with `rd_en`=1 and `rd_addr`=0 places capture bits [7:0] on `rd_data` after the next clock edge. On the same edge it copies capture bits [15:8] into the holding byte.
- R6: A read with `rd_en`=1 and `rd_addr`=1 places the holding byte on `rd_data` after the next clock edge, not the live high byte.
- R7: `flag_clr`=1 for one cycle clears the flag on the next clock edge.
- R8: If a capture and `flag_clr` fall on the same edge, the flag ends up set.
- R9: The counter adds one on each clock edge while `cnt_en`=1 and holds its value while `cnt_en`=0.
- R10: The counter wraps from 0xFFFF to 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_en | input | 1 | Counter count enable |
| cap_in | input | 1 | Asynchronous capture input |
| edge_fall | input | 1 | Transition select: 0 selects rising, 1 selects falling |
| flag_clr | input | 1 | Flag clear strobe |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 1 | Byte select: 0 is the low byte, 1 is the high byte |
| rd_data | output | 8 | Read data, registered |
| cap_flag | output | 1 | Capture flag |

## Verification
A capture input change driven between clock edges shows up as a flag and register update on the third rising edge. The bench checks that the flag is still low after two edges and high after three. A read result and a flag clear each appear one edge after the strobe, and the bench samples them at the falling edge that follows. The counter is stopped before each capture, so the expected captured value is the number of enabled cycles the bench has counted, including a run of just over 64K cycles that crosses the wrap.

// File: rtl/tcap_pkg.sv
package tcap_pkg;
    localparam int BUS_W = 8;
    localparam int CNT_W = 2 * BUS_W;

    typedef struct packed {
        logic s1;
        logic s2;
        logic prev;
    } sync_t;

    typedef struct packed {
        logic [CNT_W-1:0] cap;
        logic             flag;
    } cap_t;

    typedef struct packed {
        logic [BUS_W-1:0] hold;
        logic [BUS_W-1:0] data;
    } rd_t;
endpackage

// File: rtl/tcap_sync.sv
module tcap_sync
    import tcap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cap_in,
    input  logic edge_fall,
    output logic hit
);
    sync_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.s1   = cap_in;
        st_d.s2   = st_q.s1;
        st_d.prev = st_q.s2;
        hit = edge_fall ? (st_q.prev & ~st_q.s2) : (~st_q.prev & st_q.s2);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2: a hit only ever follows a change of the synchronized level
    a_r2_hit_on_change: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (st_q.s2 != st_q.prev));
endmodule

// File: rtl/tcap_counter.sv
module tcap_counter
    import tcap_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (en) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;

    a_r10_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (en && cnt_q == CNT_MAX) |=> (cnt_q == '0));
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(cnt_q));
endmodule

// File: rtl/tcap_capture.sv
module tcap_capture
    import tcap_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit,
    input  logic             clr,
    input  logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] cap,
    output logic             flag
);
    cap_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) st_d.flag = 1'b0;
        if (hit) begin
            st_d.cap  = cnt;
            st_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cap  = st_q.cap;
    assign flag = st_q.flag;

    a_r4_load_and_flag: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (st_q.flag && st_q.cap == $past(cnt)));
    a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !hit) |=> !st_q.flag);
    a_r2_no_hit_no_load: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> $stable(st_q.cap));
endmodule

// File: rtl/tcap_rdport.sv
module tcap_rdport
    import tcap_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  logic             rd_addr,
    input  logic [CNT_W-1:0] cap,
    output logic [BUS_W-1:0] rd_data
);
    rd_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rd_en) begin
            if (!rd_addr) begin
                st_d.data = cap[BUS_W-1:0];
                st_d.hold = cap[CNT_W-1:BUS_W];
            end else begin
                st_d.data = st_q.hold;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data = st_q.data;

    a_r5_low_parks_high: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !rd_addr) |=> (st_q.hold == $past(cap[CNT_W-1:BUS_W])));
    a_r6_high_from_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr) |=> (rd_data == $past(st_q.hold)));
endmodule

// File: rtl/tcap_unit.sv
module tcap_unit
    import tcap_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic             cap_in,
    input  logic             edge_fall,
    input  logic             flag_clr,
    input  logic             rd_en,
    input  logic             rd_addr,
    output logic [BUS_W-1:0] rd_data,
    output logic             cap_flag
);
    logic             hit;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cap;

    tcap_sync u_sync (
        .clk(clk), .rst_n(rst_n), .cap_in(cap_in), .edge_fall(edge_fall), .hit(hit)
    );

    tcap_counter u_cnt (
        .clk(clk), .rst_n(rst_n), .en(cnt_en), .cnt(cnt)
    );

    tcap_capture u_cap (
        .clk(clk), .rst_n(rst_n), .hit(hit), .clr(flag_clr), .cnt(cnt),
        .cap(cap), .flag(cap_flag)
    );

    tcap_rdport u_rd (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr), .cap(cap),
        .rd_data(rd_data)
    );

    a_r8_capture_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && flag_clr) |=> cap_flag);
endmodule

// File: tb/sim_tcap_unit.sv
module sim_tcap_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cnt_en = 1'b0, cap_in = 1'b0, edge_fall = 1'b0, flag_clr = 1'b0;
    logic       rd_en = 1'b0, rd_addr = 1'b0;
    logic [7:0] rd_data;
    logic       cap_flag;
    int         total = 0, bad = 0;

    always #4 clk = ~clk;

    tcap_unit u0 (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .cap_in(cap_in),
        .edge_fall(edge_fall), .flag_clr(flag_clr), .rd_en(rd_en),
        .rd_addr(rd_addr), .rd_data(rd_data), .cap_flag(cap_flag)
    );

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic run(input int n);
        @(negedge clk) cnt_en = 1'b1;
        repeat (n) @(negedge clk);
        cnt_en = 1'b0;
    endtask

    task automatic rd(input logic a, output int v);
        @(negedge clk) begin rd_en = 1'b1; rd_addr = a; end
        @(negedge clk) begin rd_en = 1'b0; v = rd_data; end
    endtask

    task automatic set_cap(input logic v);
        @(negedge clk) cap_in = v;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset;
        int v;
        check("R1 flag", cap_flag, 0);
        check("R1 rd_data", rd_data, 0);
        rd(1'b0, v); check("R1 low", v, 0);
        rd(1'b1, v); check("R1 high", v, 0);
    endtask

    task automatic t_rise_capture;
        int v;
        run(258);
        @(negedge clk) cap_in = 1'b1;
        repeat (2) @(negedge clk);
        check("R3 no early capture", cap_flag, 0);
        @(negedge clk);
        check("R4 flag with load", cap_flag, 1);
        rd(1'b0, v); check("R5 R9 low byte", v, 8'h02);
        rd(1'b1, v); check("R6 high byte", v, 8'h01);
    endtask

    task automatic t_clear;
        @(negedge clk) flag_clr = 1'b1;
        @(negedge clk) flag_clr = 1'b0;
        check("R7 clear", cap_flag, 0);
    endtask

    task automatic t_edge_select;
        int v;
        run(514);
        set_cap(1'b0);
        check("R2 falling ignored flag", cap_flag, 0);
        rd(1'b0, v); check("R2 falling ignored reg", v, 8'h02);
        @(negedge clk) edge_fall = 1'b1;
        set_cap(1'b1);
        check("R2 rising ignored flag", cap_flag, 0);
        set_cap(1'b0);
        check("R2 falling captured flag", cap_flag, 1);
        rd(1'b0, v); check("R2 falling captured low", v, 8'h04);
    endtask

    task automatic t_hold_snapshot;
        int v;
        run(514);
        set_cap(1'b1);
        set_cap(1'b0);
        rd(1'b1, v); check("R6 stale high from hold", v, 8'h03);
        rd(1'b0, v); check("R5 new low", v, 8'h06);
        rd(1'b1, v); check("R6 new high", v, 8'h05);
    endtask

    task automatic t_race;
        set_cap(1'b1);
        @(negedge clk) cap_in = 1'b0;
        @(negedge clk);
        @(negedge clk) flag_clr = 1'b1;
        @(negedge clk) flag_clr = 1'b0;
        check("R8 capture wins", cap_flag, 1);
        @(negedge clk) flag_clr = 1'b1;
        @(negedge clk) flag_clr = 1'b0;
        check("R7 clear alone", cap_flag, 0);
    endtask

    task automatic t_wrap;
        int v;
        run(65536 - 16'h0506 + 3);
        set_cap(1'b1);
        set_cap(1'b0);
        rd(1'b0, v); check("R10 wrap low", v, 8'h03);
        rd(1'b1, v); check("R10 wrap high", v, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_rise_capture();
        t_clear();
        t_edge_select();
        t_hold_snapshot();
        t_race();
        t_wrap();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule